// File: doc/BRIEF.md
# Transmit Buffer Host Write Port

This block sits between a simple host register bus and a byte-addressed transmit packet buffer. A processor fills the buffer one bus cycle at a time by writing to a data port. The block works out the buffer address from a page pointer and an internal byte offset. After each write the offset moves on by the host word size. The host works in either a 32-bit or a 16-bit mode, chosen by a configuration input. The mode sets which byte lanes reach the buffer and how far the offset advances.

The host has no hardware ready pin, so it handshakes through status bits. One bit reads busy while the buffer commits the last write. A second bit handles a polled read: the host starts a one-word read of the buffer at the current position, then polls until the word is ready. A third bit mirrors a pin that signals receive data is waiting. A data write issued while the port is busy is dropped, and a sticky overrun bit is set. The host can clear that bit.

Top module: `txbuf_host_port`

## Requirements
- R1: In 32-bit mode (`halfWidth`=0), a write to offset 0x34 carries four bytes. Bus bits [8i+7:8i] are the byte at offset 0x34+i: lane 0 is byte 0 (LSB) and lane 3 is byte 3 (MSB). The byte on lane i goes to buffer byte address base+i, so `bufWrData` = `hostWrData` and `bufWrBe` = 4'b1111.
- R2: In 16-bit mode (`halfWidth`=1), only lanes 0 (byte 0) and 1 (byte 1, MSB) are written. `bufWrBe` = 4'b0011, and bits [31:16] of `bufWrData` are zero whatever the host drives on them.
- R3: An accepted data write raises `bufWrEn` for exactly one cycle, in the cycle after the accepting clock edge. It uses buffer address {page pointer, byte offset}, with the offset taken before the increment.
- R4: Each accepted data write advances the byte offset by 4 in 32-bit mode and by 2 in 16-bit mode. The offset wraps modulo 2^OFF_W, which is the page size.
- R5: Status register 0x3A bit 0 (write-busy) reads 1 for exactly COMMIT_CYCLES (default 2) cycles after an accepting edge and 0 otherwise. A second data transfer cannot start inside that window.
- R6: A data write while write-busy is 1 produces no buffer write and does not move the offset. It sets the sticky overrun bit, which is 0x3A bit 3. Writing 0x3A with bit 3 set clears the overrun bit.
- R7: A write to offset 0x30 loads the page pointer from `hostWrData[PAGE_W-1:0]` and resets the byte offset to 0. Offset 0x30 reads back the page pointer.
- R8: Writing 0x3A with bit 1 set, while no read is pending, does the following. `rdReq` pulses for one cycle in the next cycle, with `rdAddr` = {page, offset}. Bit 1 then reads 1 until `rdValid` returns. The returned word is latched and readable at offset 0x3C.
- R9: 0x3A bit 2 always equals the `rxReqBar` input pin.
- R10: After reset, 0x3A bits 0, 1 and 3 are 0, the page pointer is 0 and the byte offset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostAddr | input | 8 | Host register offset |
| hostWrData | input | 32 | Host write data, lane i = offset+i |
| hostRdData | output | 32 | Read data for `hostAddr` (combinational) |
| halfWidth | input | 1 | 1 selects 16-bit host mode |
| rxReqBar | input | 1 | Receive-data-request-bar pin, mirrored in status |
| bufWrEn | output | 1 | Buffer write strobe |
| bufWrAddr | output | PAGE_W+OFF_W | Buffer byte address of the write |
| bufWrData | output | 32 | Buffer write data, byte 0 in bits [7:0] |
| bufWrBe | output | 4 | Buffer byte enables |
| rdReq | output | 1 | Buffer read request pulse |
| rdAddr | output | PAGE_W+OFF_W | Buffer byte address of the read |
| rdValid | input | 1 | Buffer read data valid |
| rdData | input | 32 | Buffer read data |

## Verification
A wrong byte offset shows up on the very next accepted write: `bufWrAddr` differs from the value predicted from the page and the count of writes in each mode. A corrupted busy counter shows on the status port within COMMIT_CYCLES cycles of a write. It shows either as a window that is too short or too long, or as a second `bufWrEn` that the bench never expected. A lost overrun flag or a stuck read-pending bit can be seen on the next status poll. A wrong read address shows when the word returned at 0x3C disagrees with the bytes the bench wrote at that position.

// File: rtl/txbuf_port_pkg.sv
package txbuf_port_pkg;
  localparam logic [7:0] ADDR_PAGE  = 8'h30;
  localparam logic [7:0] ADDR_DATA  = 8'h34;
  localparam logic [7:0] ADDR_PROTO = 8'h3A;
  localparam logic [7:0] ADDR_RDATA = 8'h3C;

  localparam int BIT_WRBUSY  = 0;
  localparam int BIT_RDPEND  = 1;
  localparam int BIT_RXBAR   = 2;
  localparam int BIT_OVERRUN = 3;

  typedef struct packed {
    logic acceptWr;
    logic loadPage;
    logic startRd;
    logic captureRd;
  } portStrobes_t;
endpackage

// File: rtl/txbuf_port_ctrl.sv
module txbuf_port_ctrl
  import txbuf_port_pkg::*;
#(
  parameter int COMMIT_CYCLES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hostWrEn,
  input  logic [7:0]   hostAddr,
  input  logic [3:0]   cmdBits,
  input  logic         rdValid,
  output portStrobes_t strobes,
  output logic         wrBusy,
  output logic         rdPending,
  output logic         overrun
);
  localparam int BUSY_W = $clog2(COMMIT_CYCLES + 1);
  localparam logic [BUSY_W-1:0] COMMIT_LOAD = BUSY_W'(COMMIT_CYCLES);

  logic [BUSY_W-1:0] busyCnt;
  logic dataHit, protoHit;

  assign dataHit  = hostWrEn && (hostAddr == ADDR_DATA);
  assign protoHit = hostWrEn && (hostAddr == ADDR_PROTO);
  assign wrBusy   = (busyCnt != '0);

  always_comb begin
    strobes.acceptWr  = dataHit && !wrBusy;
    strobes.loadPage  = hostWrEn && (hostAddr == ADDR_PAGE);
    strobes.startRd   = protoHit && cmdBits[BIT_RDPEND] && !rdPending;
    strobes.captureRd = rdValid && rdPending;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt   <= '0;
      overrun   <= 1'b0;
      rdPending <= 1'b0;
    end else begin
      if (strobes.acceptWr)   busyCnt <= COMMIT_LOAD;
      else if (wrBusy)        busyCnt <= busyCnt - 1'b1;

      if (dataHit && wrBusy)  overrun <= 1'b1;
      else if (protoHit && cmdBits[BIT_OVERRUN]) overrun <= 1'b0;

      if (strobes.startRd)    rdPending <= 1'b1;
      else if (strobes.captureRd) rdPending <= 1'b0;
    end
  end
endmodule

// File: rtl/txbuf_port_datapath.sv
module txbuf_port_datapath
  import txbuf_port_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int OFF_W  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  portStrobes_t             strobes,
  input  logic                     halfWidth,
  input  logic [31:0]              hostWrData,
  input  logic [31:0]              rdData,
  output logic                     bufWrEn,
  output logic [PAGE_W+OFF_W-1:0]  bufWrAddr,
  output logic [31:0]              bufWrData,
  output logic [3:0]               bufWrBe,
  output logic                     rdReq,
  output logic [PAGE_W+OFF_W-1:0]  rdAddr,
  output logic [31:0]              rdWord,
  output logic [PAGE_W-1:0]        pagePtr
);
  localparam int LANES = 4;
  localparam int ADDR_W = PAGE_W + OFF_W;
  localparam logic [OFF_W-1:0] STEP_FULL = OFF_W'(4);
  localparam logic [OFF_W-1:0] STEP_HALF = OFF_W'(2);

  logic [OFF_W-1:0]  byteCnt;
  logic [31:0]       laneData;
  logic [LANES-1:0]  laneKeep;
  logic [OFF_W-1:0]  step;
  logic [ADDR_W-1:0] curAddr;

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign laneKeep[lane] = !halfWidth || (lane < 2);
    assign laneData[lane*8 +: 8] = laneKeep[lane] ? hostWrData[lane*8 +: 8] : 8'h00;
  end

  assign step    = halfWidth ? STEP_HALF : STEP_FULL;
  assign curAddr = {pagePtr, byteCnt};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt   <= '0;
      pagePtr   <= '0;
      bufWrEn   <= 1'b0;
      bufWrAddr <= '0;
      bufWrData <= '0;
      bufWrBe   <= '0;
      rdReq     <= 1'b0;
      rdAddr    <= '0;
      rdWord    <= '0;
    end else begin
      bufWrEn <= strobes.acceptWr;
      rdReq   <= strobes.startRd;
      if (strobes.acceptWr) begin
        bufWrAddr <= curAddr;
        bufWrData <= laneData;
        bufWrBe   <= laneKeep;
        byteCnt   <= byteCnt + step;
      end
      if (strobes.loadPage) begin
        pagePtr <= hostWrData[PAGE_W-1:0];
        byteCnt <= '0;
      end
      if (strobes.startRd)   rdAddr <= curAddr;
      if (strobes.captureRd) rdWord <= rdData;
    end
  end
endmodule

// File: rtl/txbuf_host_port.sv
module txbuf_host_port
  import txbuf_port_pkg::*;
#(
  parameter int PAGE_W        = 4,
  parameter int OFF_W         = 8,
  parameter int COMMIT_CYCLES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     hostWrEn,
  input  logic [7:0]               hostAddr,
  input  logic [31:0]              hostWrData,
  output logic [31:0]              hostRdData,
  input  logic                     halfWidth,
  input  logic                     rxReqBar,
  output logic                     bufWrEn,
  output logic [PAGE_W+OFF_W-1:0]  bufWrAddr,
  output logic [31:0]              bufWrData,
  output logic [3:0]               bufWrBe,
  output logic                     rdReq,
  output logic [PAGE_W+OFF_W-1:0]  rdAddr,
  input  logic                     rdValid,
  input  logic [31:0]              rdData
);
  portStrobes_t      strobes;
  logic              wrBusy, rdPending, overrun;
  logic [31:0]       rdWord;
  logic [PAGE_W-1:0] pagePtr;
  logic [31:0]       statusWord;

  txbuf_port_ctrl #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .cmdBits(hostWrData[3:0]), .rdValid(rdValid), .strobes(strobes),
    .wrBusy(wrBusy), .rdPending(rdPending), .overrun(overrun)
  );

  txbuf_port_datapath #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .halfWidth(halfWidth),
    .hostWrData(hostWrData), .rdData(rdData), .bufWrEn(bufWrEn),
    .bufWrAddr(bufWrAddr), .bufWrData(bufWrData), .bufWrBe(bufWrBe),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdWord(rdWord), .pagePtr(pagePtr)
  );

  always_comb begin
    statusWord = '0;
    statusWord[BIT_WRBUSY]  = wrBusy;
    statusWord[BIT_RDPEND]  = rdPending;
    statusWord[BIT_RXBAR]   = rxReqBar;
    statusWord[BIT_OVERRUN] = overrun;
  end

  always_comb begin
    case (hostAddr)
      ADDR_PROTO: hostRdData = statusWord;
      ADDR_PAGE:  hostRdData = 32'(pagePtr);
      ADDR_RDATA: hostRdData = rdWord;
      default:    hostRdData = '0;
    endcase
  end
endmodule

// File: rtl/txbuf_host_port_chk.sv
module txbuf_host_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hostWrEn,
  input logic [7:0] hostAddr,
  input logic [3:0] cmdBits,
  input logic       halfWidth,
  input logic       bufWrEn,
  input logic [3:0] bufWrBe,
  input logic       rdReq,
  input logic       wrBusy,
  input logic       rdPending,
  input logic       overrun
);
  // R3/R5: one beat per accepted write, never back to back
  assert_single_beat_R3: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |=> !bufWrEn);

  // R5: commit window is open whenever the buffer is written
  assert_busy_in_commit_R5: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> wrBusy);

  // R1/R2: byte enables follow the mode seen at the accepting edge
  assert_lane_mode_R2: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> (bufWrBe == ($past(halfWidth) ? 4'b0011 : 4'b1111)));

  // R6: overrun only clears through the protocol register
  assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !(hostWrEn && hostAddr == 8'h3A && cmdBits[3])) |=> overrun);

  // R8: a read request is issued only with the pending bit up
  assert_read_pending_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> rdPending);
endmodule

bind txbuf_host_port txbuf_host_port_chk u_chk (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
  .cmdBits(hostWrData[3:0]), .halfWidth(halfWidth), .bufWrEn(bufWrEn),
  .bufWrBe(bufWrBe), .rdReq(rdReq), .wrBusy(wrBusy),
  .rdPending(rdPending), .overrun(overrun)
);

// File: tb/txbuf_host_port_tb.sv
module txbuf_host_port_tb;
  localparam int PAGE_W = 4;
  localparam int OFF_W  = 8;
  localparam int ADDR_W = PAGE_W + OFF_W;
  localparam int PAGE_BYTES = 1 << OFF_W;

  logic clk = 0, rstN = 0;
  logic hostWrEn = 0, halfWidth = 0, rxReqBar = 1, rdValid = 0;
  logic [7:0] hostAddr = 8'h00;
  logic [31:0] hostWrData = '0, rdData = '0, hostRdData, bufWrData;
  logic bufWrEn, rdReq;
  logic [ADDR_W-1:0] bufWrAddr, rdAddr;
  logic [3:0] bufWrBe;

  int checks = 0, errors = 0;
  bit done = 0;
  int modelPage = 0, modelCnt = 0;
  logic [7:0] modelMem [0:(1<<ADDR_W)-1];
  logic [7:0] seenMem  [0:(1<<ADDR_W)-1];
  int unsigned qAddr[$], qData[$], qBe[$];

  always #10 clk = ~clk;

  txbuf_host_port u_dut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .halfWidth(halfWidth),
    .rxReqBar(rxReqBar), .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr),
    .bufWrData(bufWrData), .bufWrBe(bufWrBe), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdValid(rdValid), .rdData(rdData)
  );

  task automatic check(input bit ok, input string req, input int unsigned act, input int unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [7:0] a, output logic [31:0] v);
    hostAddr = a;
    #1 v = hostRdData;
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 0;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    readReg(8'h3A, v);
    while (v[0]) begin
      @(negedge clk);
      readReg(8'h3A, v);
    end
  endtask

  // driver: predict the buffer write, push it, then perform the bus write
  task automatic dataWrite(input logic [31:0] d);
    int unsigned a, be, dd;
    a  = modelPage * PAGE_BYTES + modelCnt;
    be = halfWidth ? 4'b0011 : 4'b1111;
    dd = halfWidth ? {16'h0, d[15:0]} : d;
    qAddr.push_back(a); qData.push_back(dd); qBe.push_back(be);
    for (int i = 0; i < 4; i++) if (be[i]) modelMem[a + i] = dd[i*8 +: 8];
    modelCnt = (modelCnt + (halfWidth ? 2 : 4)) % PAGE_BYTES;
    busWrite(8'h34, d);
  endtask

  task automatic setPage(input int p);
    busWrite(8'h30, 32'(p));
    modelPage = p; modelCnt = 0;
  endtask

  // monitor: compare every buffer write against the queue (R1 R2 R3 R4)
  always @(negedge clk) begin
    if (rstN && bufWrEn) begin
      for (int i = 0; i < 4; i++) if (bufWrBe[i]) seenMem[bufWrAddr + i] = bufWrData[i*8 +: 8];
      if (qAddr.size() == 0) begin
        check(0, "R3/R6 unexpected buffer write", bufWrAddr, 0);
      end else begin
        int unsigned ea, ed, eb;
        ea = qAddr.pop_front(); ed = qData.pop_front(); eb = qBe.pop_front();
        check(bufWrAddr == ea[ADDR_W-1:0], "R3/R4 address", bufWrAddr, ea);
        check(bufWrData == ed, "R1/R2 data", bufWrData, ed);
        check(bufWrBe == eb[3:0], "R1/R2 byte enables", bufWrBe, eb);
      end
    end
  end

  // buffer read responder, three cycles of latency
  initial begin
    forever begin
      @(negedge clk);
      if (rdReq) begin
        logic [ADDR_W-1:0] ra;
        ra = rdAddr;
        repeat (3) @(negedge clk);
        rdData = {seenMem[ra+3], seenMem[ra+2], seenMem[ra+1], seenMem[ra]};
        rdValid = 1;
        @(negedge clk);
        rdValid = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int polls;
    for (int i = 0; i < (1<<ADDR_W); i++) begin modelMem[i] = 8'h00; seenMem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R10: reset state
    readReg(8'h3A, v);
    check(v == 32'h4, "R10 status after reset", v, 32'h4);
    readReg(8'h30, v);
    check(v == 0, "R10 page after reset", v, 0);

    // R1 R3 R5: 32-bit write and busy window
    dataWrite(32'hA1B2C3D4);
    readReg(8'h3A, v);
    check(v[0] == 1, "R5 busy cycle 1", v[0], 1);
    @(negedge clk); readReg(8'h3A, v);
    check(v[0] == 1, "R5 busy cycle 2", v[0], 1);
    @(negedge clk); readReg(8'h3A, v);
    check(v[0] == 0, "R5 idle after window", v[0], 0);

    // R4: next word at +4
    dataWrite(32'h11223344);
    // R6: write inside busy window is dropped
    hostWrEn = 1; hostAddr = 8'h34; hostWrData = 32'hDEADBEEF;
    @(negedge clk);
    hostWrEn = 0;
    readReg(8'h3A, v);
    check(v[3] == 1, "R6 overrun set", v[3], 1);
    waitIdle();
    dataWrite(32'h55667788);   // must land at offset 8, not 12
    waitIdle();
    readReg(8'h3A, v);
    check(v[3] == 1, "R6 overrun sticky", v[3], 1);
    busWrite(8'h3A, 32'h8);
    readReg(8'h3A, v);
    check(v[3] == 0, "R6 overrun cleared", v[3], 0);

    // R2 R4: 16-bit mode, upper lanes dropped, step 2
    halfWidth = 1;
    for (int k = 0; k < 3; k++) begin
      dataWrite(32'hFFFF0000 | (32'h0101 * (k + 1)));
      waitIdle();
    end
    halfWidth = 0;
    dataWrite(32'hCAFEF00D);   // offset 18
    waitIdle();

    // R7: page load resets offset
    setPage(5);
    readReg(8'h30, v);
    check(v == 5, "R7 page readback", v, 5);
    dataWrite(32'h0BADC0DE);
    waitIdle();

    // R4: wrap within page 2 after a full page of 32-bit words
    setPage(2);
    for (int k = 0; k < PAGE_BYTES/4 + 1; k++) begin
      dataWrite(32'h10000000 + k);
      waitIdle();
    end
    check(modelCnt == 4, "R4 model wrap position", modelCnt, 4);

    // R8: polled read of offset 0 in page 5
    setPage(5);
    busWrite(8'h3A, 32'h2);
    readReg(8'h3A, v);
    check(v[1] == 1, "R8 read pending", v[1], 1);
    polls = 0;
    while (v[1] && polls < 50) begin
      @(negedge clk); readReg(8'h3A, v); polls++;
    end
    check(v[1] == 0, "R8 read completes", v[1], 0);
    readReg(8'h3C, v);
    check(v == {modelMem[5*PAGE_BYTES+3], modelMem[5*PAGE_BYTES+2],
                modelMem[5*PAGE_BYTES+1], modelMem[5*PAGE_BYTES]},
          "R8 read word", v, 32'h0BADC0DE);

    // R9: receive pin mirror
    rxReqBar = 0;
    readReg(8'h3A, v);
    check(v[2] == 0, "R9 mirror low", v[2], 0);
    rxReqBar = 1;
    readReg(8'h3A, v);
    check(v[2] == 1, "R9 mirror high", v[2], 1);

    repeat (4) @(negedge clk);
    check(qAddr.size() == 0, "R3 all predicted writes seen", qAddr.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule